// File: doc/BRIEF.md
# Fractured Multiply-Accumulate Slice

This block is a pipelined multiplier slice with registers at every stage. Its multiplier resources are split at run time into independent lanes: four 9x9, three 12x12 or two 18x18 products. The same lanes can also be summed into one sum of products. That sum can be negated, added to the slice's own previous result to form an accumulator, and added to a partial sum arriving from a neighbouring slice. Before it reaches the output register, the sum is rounded at a programmable bit position and optionally clamped to the signed range of the result.

Two chain paths connect neighbouring slices. The first is an 18-bit operand chain. The captured low half of the A operand leaves on `scan_out`, and a slice can take that operand from its neighbour instead of from its own input. Chained slices then form a tap-delay line with one cycle per slice. The second is a 44-bit result chain. `sum_o` of one slice feeds `cas_in` of the next, which adds it in the final stage.

Every operation moves through three registers: input, product and result. A valid bit travels alongside the data, so a new operation can be issued on every clock.

Top module: `fdsp_slice`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `lanes_o`, `sum_o` and `scan_out` become zero.
- R2: An operation sampled with `in_valid` high at a rising edge produces `out_valid` high after the third rising edge counted from that one. Operations may be issued on consecutive cycles and complete in order. When no result completes, `out_valid` is low and `lanes_o` keeps its value.
- R3: Mode code 0 gives four lanes. Lane i multiplies `a_in[9i+8:9i]` by `b_in[9i+8:9i]` and places the low 18 bits of the product in `lanes_o[18i+17:18i]`. `sum_o` is zero.
- R4: Mode code 1 gives three lanes. Lane i multiplies the 12-bit fields at bit 12i of the two operands and places the 24-bit product at `lanes_o[24i+23:24i]`. `sum_o` is zero.
- R5: Mode code 2 gives two lanes. Lane i multiplies the 18-bit fields at bit 18i and places the 36-bit product at `lanes_o[36i+35:36i]`. `sum_o` is zero.
- R6: With `is_signed` high, every operand field is a two's-complement number. With it low, every field is unsigned.
- R7: Mode code 3 forms the sum of the two 18-bit lane products. Mode code 4 forms the sum of the four 9-bit lane products. In both modes `lanes_o` is zero. Codes 5 to 7 give zero on both `lanes_o` and `sum_o`.
- R8: With `sub_en` high, the sum of products is subtracted instead of added.
- R9: With `acc_en` high, the result adds the value of `sum_o` left by the last completed operation, taken as a signed 44-bit number.
- R10: With `chain_en` high, the result adds `cas_in` as a signed 44-bit number. `cas_in` is sampled at the edge at which the result is registered.
- R11: `clr` high at a rising edge makes `sum_o` zero after that edge. This takes priority over a result completing at the same edge.
- R12: With `rnd_en` high and `rnd_pos` = p > 0, the total is rounded half-up: 2^(p-1) is added and bits below p are cleared. p = 0 leaves the value unchanged. Rounding comes before saturation.
- R13: With `sat_en` high, totals above 2^43-1 give 2^43-1 and totals below -2^43 give -2^43. With `sat_en` low, the low 44 bits are kept.
- R14: `scan_out` shows, one edge later, the low 18 bits of the A operand the slice captured. With `scan_sel` high, that operand is `scan_in`; otherwise it is `a_in[17:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs |
| mode | input | 3 | Lane split or sum-of-products mode |
| is_signed | input | 1 | Operand fields are two's complement |
| sub_en | input | 1 | Subtract the sum of products |
| acc_en | input | 1 | Add the previous result |
| chain_en | input | 1 | Add the neighbour's partial sum |
| rnd_en | input | 1 | Enable rounding |
| rnd_pos | input | 5 | Rounding bit position |
| sat_en | input | 1 | Enable saturation |
| clr | input | 1 | Synchronous clear of the result register |
| scan_sel | input | 1 | Take A low half from the operand chain |
| a_in | input | 36 | A operand fields |
| b_in | input | 36 | B operand fields |
| scan_in | input | 18 | Operand chain from the previous slice |
| cas_in | input | 44 | Partial sum from the previous slice |
| out_valid | output | 1 | Result registers updated |
| lanes_o | output | 72 | Packed independent products |
| sum_o | output | 44 | Sum/accumulator result, also the result chain output |
| scan_out | output | 18 | Operand chain to the next slice |

## Verification
The states hardest to reach from the ports are totals that leave the 44-bit range and a clear that arrives on the same edge as a completing result. Products alone can never reach the saturation limits. The stimulus therefore loads extreme values through `cas_in` and adds or subtracts a small product, with saturation both on and off. The clear collision is produced by counting cycles after an issue and raising `clr` exactly at the third edge. Long streams of back-to-back random operations in every mode code and both signedness settings, with random accumulate, rounding and saturation, exercise the accumulator feedback at full rate.

// File: rtl/fdsp_pkg.sv
`timescale 1ns/1ps
package fdsp_pkg;
    localparam int OPND_W  = 36;
    localparam int LANES_W = 2 * OPND_W;
    localparam int ACC_W   = 44;
    localparam int INT_W   = ACC_W + 2;
    localparam int RPOS_W  = 5;
    localparam int SCAN_W  = OPND_W / 2;
    localparam int MODE_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        M_IND9  = 3'd0,
        M_IND12 = 3'd1,
        M_IND18 = 3'd2,
        M_SOP2  = 3'd3,
        M_SOP4  = 3'd4
    } mode_e;

    typedef struct packed {
        logic              valid;
        logic [MODE_W-1:0] mode;
        logic              sub;
        logic              acc;
        logic              chain;
        logic              rnd;
        logic [RPOS_W-1:0] rpos;
        logic              sat;
    } ctl_t;

    function automatic logic is_sop(logic [MODE_W-1:0] m);
        return (m == M_SOP2) || (m == M_SOP4);
    endfunction

    // half-up rounding: add half an LSB of the kept part, then floor
    function automatic logic signed [INT_W-1:0] round_half_up(
        logic signed [INT_W-1:0] v, logic en, logic [RPOS_W-1:0] pos);
        logic signed [INT_W-1:0] half;
        logic signed [INT_W-1:0] keep;
        if (!en || pos == '0) return v;
        half = '0;
        half[pos - 1'b1] = 1'b1;
        keep = '1;
        keep = keep << pos;
        return (v + half) & keep;
    endfunction

    function automatic logic [ACC_W-1:0] sat_clip(logic signed [INT_W-1:0] v, logic en);
        logic [INT_W-ACC_W:0] top;
        top = v[INT_W-1:ACC_W-1];
        if (!en || (&top) || !(|top)) return v[ACC_W-1:0];
        if (v[INT_W-1]) return {1'b1, {(ACC_W-1){1'b0}}};
        return {1'b0, {(ACC_W-1){1'b1}}};
    endfunction
endpackage

// File: rtl/fdsp_mul_lane.sv
`timescale 1ns/1ps
module fdsp_mul_lane #(
    parameter int W = 9
) (
    input  logic           sgn,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] p
);
    logic signed [W:0] xe;
    logic signed [W:0] ye;

    assign xe = {sgn & x[W-1], x};
    assign ye = {sgn & y[W-1], y};
    // a WxW product of either signedness fits in 2W bits
    assign p  = (2*W)'(xe * ye);
endmodule

// File: rtl/fdsp_lanes.sv
`timescale 1ns/1ps
module fdsp_lanes
    import fdsp_pkg::*;
(
    input  logic                    sgn,
    input  logic [MODE_W-1:0]       mode,
    input  logic [OPND_W-1:0]       a,
    input  logic [OPND_W-1:0]       b,
    output logic [LANES_W-1:0]      lanes,
    output logic signed [INT_W-1:0] sop
);
    localparam int W9  = OPND_W / 4;
    localparam int W12 = OPND_W / 3;
    localparam int W18 = OPND_W / 2;

    logic [LANES_W-1:0]      pk9, pk12, pk18;
    logic signed [INT_W-1:0] e9  [4];
    logic signed [INT_W-1:0] e18 [2];

    for (genvar g = 0; g < 4; g++) begin : g_n9
        logic [2*W9-1:0] p;
        fdsp_mul_lane #(.W(W9)) u_lane (
            .sgn(sgn), .x(a[g*W9 +: W9]), .y(b[g*W9 +: W9]), .p(p));
        assign pk9[g*2*W9 +: 2*W9] = p;
        assign e9[g] = {{(INT_W-2*W9){sgn & p[2*W9-1]}}, p};
    end

    for (genvar g = 0; g < 3; g++) begin : g_n12
        logic [2*W12-1:0] p;
        fdsp_mul_lane #(.W(W12)) u_lane (
            .sgn(sgn), .x(a[g*W12 +: W12]), .y(b[g*W12 +: W12]), .p(p));
        assign pk12[g*2*W12 +: 2*W12] = p;
    end

    for (genvar g = 0; g < 2; g++) begin : g_n18
        logic [2*W18-1:0] p;
        fdsp_mul_lane #(.W(W18)) u_lane (
            .sgn(sgn), .x(a[g*W18 +: W18]), .y(b[g*W18 +: W18]), .p(p));
        assign pk18[g*2*W18 +: 2*W18] = p;
        assign e18[g] = {{(INT_W-2*W18){sgn & p[2*W18-1]}}, p};
    end

    always_comb begin
        lanes = '0;
        sop   = '0;
        case (mode)
            M_IND9:  lanes = pk9;
            M_IND12: lanes = pk12;
            M_IND18: lanes = pk18;
            M_SOP2:  sop   = e18[0] + e18[1];
            M_SOP4:  sop   = e9[0] + e9[1] + e9[2] + e9[3];
            default: ;
        endcase
    end
endmodule

// File: rtl/fdsp_outstage.sv
`timescale 1ns/1ps
module fdsp_outstage
    import fdsp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  ctl_t                    ctl,
    input  logic [LANES_W-1:0]      lanes_in,
    input  logic signed [INT_W-1:0] sop_in,
    input  logic [ACC_W-1:0]        cas_in,
    output logic                    out_valid,
    output logic [LANES_W-1:0]      lanes_o,
    output logic [ACC_W-1:0]        sum_o
);
    logic signed [INT_W-1:0] acc_t, cas_t, tot, rnd_v;
    logic [ACC_W-1:0]        res;

    always_comb begin
        acc_t = ctl.acc   ? {{(INT_W-ACC_W){sum_o[ACC_W-1]}}, sum_o}   : '0;
        cas_t = ctl.chain ? {{(INT_W-ACC_W){cas_in[ACC_W-1]}}, cas_in} : '0;
        tot   = acc_t + cas_t + (ctl.sub ? -sop_in : sop_in);
        rnd_v = round_half_up(tot, ctl.rnd, ctl.rpos);
        res   = sat_clip(rnd_v, ctl.sat);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            lanes_o   <= '0;
            sum_o     <= '0;
        end else begin
            out_valid <= ctl.valid;
            if (ctl.valid) begin
                lanes_o <= lanes_in;
                sum_o   <= is_sop(ctl.mode) ? res : '0;
            end
            if (clr) sum_o <= '0;
        end
    end
endmodule

// File: rtl/fdsp_slice.sv
`timescale 1ns/1ps
module fdsp_slice
    import fdsp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [MODE_W-1:0]   mode,
    input  logic                is_signed,
    input  logic                sub_en,
    input  logic                acc_en,
    input  logic                chain_en,
    input  logic                rnd_en,
    input  logic [RPOS_W-1:0]   rnd_pos,
    input  logic                sat_en,
    input  logic                clr,
    input  logic                scan_sel,
    input  logic [OPND_W-1:0]   a_in,
    input  logic [OPND_W-1:0]   b_in,
    input  logic [SCAN_W-1:0]   scan_in,
    input  logic [ACC_W-1:0]    cas_in,
    output logic                out_valid,
    output logic [LANES_W-1:0]  lanes_o,
    output logic [ACC_W-1:0]    sum_o,
    output logic [SCAN_W-1:0]   scan_out
);
    // stage 1: operand and control capture
    logic [OPND_W-1:0] a_q, b_q;
    logic              sgn_q;
    ctl_t              ctl1;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            sgn_q <= 1'b0;
            ctl1  <= '0;
        end else begin
            a_q   <= {a_in[OPND_W-1:SCAN_W], scan_sel ? scan_in : a_in[SCAN_W-1:0]};
            b_q   <= b_in;
            sgn_q <= is_signed;
            ctl1  <= '{valid: in_valid, mode: mode, sub: sub_en, acc: acc_en,
                       chain: chain_en, rnd: rnd_en, rpos: rnd_pos, sat: sat_en};
        end
    end

    assign scan_out = a_q[SCAN_W-1:0];

    // stage 2: lane products and sum of products
    logic [LANES_W-1:0]      lanes_c, lanes_q;
    logic signed [INT_W-1:0] sop_c, sop_q;
    ctl_t                    ctl2;

    fdsp_lanes u_lanes (
        .sgn(sgn_q), .mode(ctl1.mode), .a(a_q), .b(b_q),
        .lanes(lanes_c), .sop(sop_c));

    always_ff @(posedge clk) begin
        if (rst) begin
            lanes_q <= '0;
            sop_q   <= '0;
            ctl2    <= '0;
        end else begin
            lanes_q <= lanes_c;
            sop_q   <= sop_c;
            ctl2    <= ctl1;
        end
    end

    // stage 3: accumulate, chain, round, saturate
    fdsp_outstage u_out (
        .clk(clk), .rst(rst), .clr(clr), .ctl(ctl2),
        .lanes_in(lanes_q), .sop_in(sop_q), .cas_in(cas_in),
        .out_valid(out_valid), .lanes_o(lanes_o), .sum_o(sum_o));
endmodule

// File: rtl/fdsp_slice_chk.sv
`timescale 1ns/1ps
module fdsp_slice_chk
    import fdsp_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [MODE_W-1:0]   mode,
    input logic                clr,
    input logic                scan_sel,
    input logic [SCAN_W-1:0]   a_lo,
    input logic [SCAN_W-1:0]   scan_in,
    input logic                out_valid,
    input logic [LANES_W-1:0]  lanes_o,
    input logic [ACC_W-1:0]    sum_o,
    input logic [SCAN_W-1:0]   scan_out
);
    // edges since reset, saturating at the pipeline depth
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_lanes_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd0 && !out_valid) |-> $stable(lanes_o));

    assert_split_no_sum_R3: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && out_valid && $past(mode, 3) < 3'd3) |-> (sum_o == '0));

    assert_sum_no_lanes_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && out_valid && $past(mode, 3) >= 3'd3) |-> (lanes_o == '0));

    assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd0 && $past(clr)) |-> (sum_o == '0));

    assert_scan_R14: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd0) |-> (scan_out == $past(scan_sel ? scan_in : a_lo)));
endmodule

bind fdsp_slice fdsp_slice_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .clr(clr),
    .scan_sel(scan_sel), .a_lo(a_in[17:0]), .scan_in(scan_in),
    .out_valid(out_valid), .lanes_o(lanes_o), .sum_o(sum_o), .scan_out(scan_out));

// File: tb/sim_fdsp_slice.sv
`timescale 1ns/1ps
module sim_fdsp_slice;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 0, is_signed = 0, sub_en = 0, acc_en = 0, chain_en = 0;
    logic        rnd_en = 0, sat_en = 0, clr = 0, scan_sel = 0;
    logic [2:0]  mode = '0;
    logic [4:0]  rnd_pos = '0;
    logic [35:0] a_in = '0, b_in = '0;
    logic [17:0] scan_in = '0;
    logic [43:0] cas_in;
    logic        out_valid;
    logic [71:0] lanes_o;
    logic [43:0] sum_o;
    logic [17:0] scan_out;

    fdsp_slice u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .is_signed(is_signed),
        .sub_en(sub_en), .acc_en(acc_en), .chain_en(chain_en), .rnd_en(rnd_en),
        .rnd_pos(rnd_pos), .sat_en(sat_en), .clr(clr), .scan_sel(scan_sel),
        .a_in(a_in), .b_in(b_in), .scan_in(scan_in), .cas_in(cas_in),
        .out_valid(out_valid), .lanes_o(lanes_o), .sum_o(sum_o), .scan_out(scan_out));

    always #10 clk = ~clk;

    typedef struct {
        logic [71:0] ln;
        logic [43:0] sm;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          nchk = 0, nerr = 0;
    longint      prev = 0;
    logic [43:0] cas_b = '0;
    logic [71:0] last_ln = '0;
    bit          seen = 0;
    localparam longint MAXV = (64'sd1 <<< 43) - 1;
    localparam longint MINV = -(64'sd1 <<< 43);

    assign cas_in = cas_b;

    task automatic check(string tag, string what, logic [71:0] act, logic [71:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic longint sx44(logic [43:0] v);
        return v[43] ? longint'(v) - (64'sd1 <<< 44) : longint'(v);
    endfunction

    function automatic longint fld(logic [35:0] v, int lo, int w, bit sg);
        longint x;
        x = longint'(v >> lo) & ((64'sd1 <<< w) - 1);
        if (sg && x[w-1]) x = x - (64'sd1 <<< w);
        return x;
    endfunction

    function automatic logic [35:0] pick36();
        case ($urandom % 5)
            0: return '0;
            1: return '1;
            2: return 36'h804020100;
            default: return 36'({$urandom(), $urandom()});
        endcase
    endfunction

    // drive one operation and queue the expected result
    task automatic op(int md, bit sg, bit sb, bit ac, bit ch, bit rn, int rp, bit st,
                      logic [35:0] a, logic [35:0] b, string tag);
        exp_t        e;
        logic [35:0] ae;
        int          w, n;
        longint      s, v, p;
        in_valid = 1; mode = 3'(md); is_signed = sg; sub_en = sb; acc_en = ac;
        chain_en = ch; rnd_en = rn; rnd_pos = 5'(rp); sat_en = st; a_in = a; b_in = b;
        ae = scan_sel ? {a[35:18], scan_in} : a;
        e.ln = '0; e.sm = '0; e.tag = tag; s = 0;
        case (md)
            0, 4:    begin w = 9;  n = 4; end
            1:       begin w = 12; n = 3; end
            2, 3:    begin w = 18; n = 2; end
            default: begin w = 0;  n = 0; end
        endcase
        for (int i = 0; i < n; i++) begin
            p = fld(ae, i*w, w, sg) * fld(b, i*w, w, sg);
            if (md < 3) e.ln = e.ln | (72'(p & ((64'sd1 <<< (2*w)) - 1)) << (i*2*w));
            s += p;
        end
        if (md == 3 || md == 4) begin
            v = (ac ? prev : 64'sd0) + (ch ? sx44(cas_b) : 64'sd0) + (sb ? -s : s);
            if (rn && rp > 0) v = ((v + (64'sd1 <<< (rp-1))) >>> rp) <<< rp;
            if (st) begin
                if (v > MAXV) v = MAXV;
                else if (v < MINV) v = MINV;
            end
            e.sm = v[43:0];
            prev = sx44(e.sm);
        end else begin
            prev = 0;
        end
        q.push_back(e);
    endtask

    task automatic tick();
        exp_t e;
        @(negedge clk);
        if (out_valid) begin
            if (q.size() == 0) check("R2", "unexpected out_valid", 72'd1, 72'd0);
            else begin
                e = q.pop_front();
                check(e.tag, "lanes_o", lanes_o, e.ln);
                check(e.tag, "sum_o", sum_o, e.sm);
                last_ln = e.ln;
                seen = 1;
            end
        end else if (seen) begin
            check("R2", "lanes_o held while idle", lanes_o, last_ln);
        end
        in_valid = 0;
        clr = 0;
    endtask

    task automatic drain();
        repeat (4) tick();
        check("R2", "no result left outstanding", 72'(q.size()), 72'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        // R1: reset clears everything even with activity on the inputs
        in_valid = 1; a_in = '1; b_in = '1; scan_in = '1; mode = 3'd3;
        repeat (3) @(negedge clk);
        in_valid = 0; a_in = '0; b_in = '0; scan_in = '0; mode = '0;
        check("R1", "out_valid", 72'(out_valid), 72'd0);
        check("R1", "lanes_o", lanes_o, 72'd0);
        check("R1", "sum_o", 72'(sum_o), 72'd0);
        check("R1", "scan_out", 72'(scan_out), 72'd0);
        rst = 0;

        // R2: three-edge latency
        op(2, 0, 0, 0, 0, 0, 0, 0, {18'd3, 18'd5}, {18'd7, 18'd11}, "R2 R5");
        tick(); check("R2", "pending after edge 1", 72'(q.size()), 72'd1);
        tick(); check("R2", "pending after edge 2", 72'(q.size()), 72'd1);
        tick(); check("R2", "done after edge 3", 72'(q.size()), 72'd0);
        drain();

        // R6: all-ones fields, signed and unsigned, each split
        for (int md = 0; md < 3; md++) begin
            op(md, 1, 0, 0, 0, 0, 0, 0, '1, '1, "R6 signed");
            tick();
            op(md, 0, 0, 0, 0, 0, 0, 0, '1, '1, "R6 unsigned");
            tick();
            op(md, 1, 0, 0, 0, 0, 0, 0, 36'h804020100, '1, "R6 min by minus one");
            tick();
        end
        drain();

        // R8: subtraction of the sum of products
        op(3, 0, 0, 0, 0, 0, 0, 0, {18'd2, 18'd5}, {18'd3, 18'd7}, "R8 add");
        tick();
        op(3, 0, 1, 0, 0, 0, 0, 0, {18'd2, 18'd5}, {18'd3, 18'd7}, "R8 subtract");
        tick();
        drain();

        // R11 then R9: clear, then accumulate back to back
        clr = 1; prev = 0;
        tick();
        check("R11", "sum_o after clear", 72'(sum_o), 72'd0);
        for (int k = 0; k < 3; k++) begin
            op(4, 0, 0, 1, 0, 0, 0, 0, {4{9'd2}}, {4{9'd3}}, "R9 accumulate");
            tick();
        end
        op(4, 1, 1, 1, 0, 0, 0, 0, {4{9'd2}}, {4{9'd3}}, "R9 accumulate subtract");
        tick();
        drain();

        // R11: clear wins over a result completing at the same edge
        op(3, 0, 0, 1, 0, 0, 0, 0, {18'd1, 18'd9}, {18'd1, 18'd9}, "R11 clear priority");
        tick(); tick();
        clr = 1; q[$].sm = '0; prev = 0;
        tick();
        drain();

        // R10: cascade input
        cas_b = 44'd1000;
        op(3, 0, 0, 0, 1, 0, 0, 0, {18'd0, 18'd5}, {18'd0, 18'd7}, "R10 chain on");
        tick();
        op(3, 0, 0, 0, 0, 0, 0, 0, {18'd0, 18'd5}, {18'd0, 18'd7}, "R10 chain off");
        tick();
        drain();
        cas_b = 44'hFFF_FFFF_FC18;
        op(4, 1, 0, 0, 1, 0, 0, 0, {4{9'd1}}, {4{9'd1}}, "R10 negative chain");
        tick();
        drain();
        cas_b = '0;

        // R12: rounding half-up
        op(3, 1, 0, 0, 0, 1, 1, 0, {18'd0, 18'd3}, {18'd0, 18'd1}, "R12 3 at bit 1");
        tick();
        op(3, 1, 0, 0, 0, 1, 1, 0, {18'd0, 18'h3FFFD}, {18'd0, 18'd1}, "R12 -3 at bit 1");
        tick();
        op(3, 1, 0, 0, 0, 1, 2, 0, {18'd0, 18'd2}, {18'd0, 18'd1}, "R12 2 at bit 2");
        tick();
        op(3, 1, 0, 0, 0, 1, 2, 0, {18'd0, 18'd1}, {18'd0, 18'd1}, "R12 1 at bit 2");
        tick();
        op(3, 1, 0, 0, 0, 1, 0, 0, {18'd0, 18'd3}, {18'd0, 18'd1}, "R12 position zero");
        tick();
        drain();

        // R13: saturation and wrap at both ends
        cas_b = 44'h7FF_FFFF_FFFF;
        op(3, 0, 0, 0, 1, 0, 0, 1, {18'd0, 18'd1}, {18'd0, 18'd1}, "R13 clamp high");
        tick();
        op(3, 0, 0, 0, 1, 0, 0, 0, {18'd0, 18'd1}, {18'd0, 18'd1}, "R13 wrap high");
        tick();
        op(3, 0, 0, 0, 1, 1, 8, 1, {18'd0, 18'd200}, {18'd0, 18'd1}, "R13 R12 round then clamp");
        tick();
        drain();
        cas_b = 44'h800_0000_0000;
        op(3, 0, 1, 0, 1, 0, 0, 1, {18'd0, 18'd1}, {18'd0, 18'd1}, "R13 clamp low");
        tick();
        op(3, 0, 1, 0, 1, 0, 0, 0, {18'd0, 18'd1}, {18'd0, 18'd1}, "R13 wrap low");
        tick();
        drain();
        cas_b = '0;

        // R14: operand chain
        scan_sel = 1; scan_in = 18'd300;
        op(2, 0, 0, 0, 0, 0, 0, 0, {18'd2, 18'd9}, {18'd4, 18'd3}, "R14 chained operand");
        tick();
        check("R14", "scan_out from chain", 72'(scan_out), 72'd300);
        scan_in = 18'd77;
        tick();
        check("R14", "scan_out follows chain", 72'(scan_out), 72'd77);
        scan_sel = 0; a_in = {18'd1, 18'd5};
        tick();
        check("R14", "scan_out from a_in", 72'(scan_out), 72'd5);
        drain();

        // sweeps over every mode code and signedness
        for (int md = 0; md < 8; md++) begin
            for (int sg = 0; sg < 2; sg++) begin
                cas_b = 44'({$urandom(), $urandom()});
                for (int n = 0; n < 60; n++) begin
                    scan_sel = 1'($urandom % 4 == 0);
                    scan_in  = 18'($urandom);
                    op(md, 1'(sg), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                       int'($urandom % 32), 1'($urandom), pick36(), pick36(),
                       md == 0 ? "R3 R6" : md == 1 ? "R4 R6" : md == 2 ? "R5 R6" : "R7 R6");
                    tick();
                end
                scan_sel = 0;
                drain();
            end
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule